// File: doc/BRIEF.md
# Work-Aware Tile Clock Throttle

This block derives a tile's working clock from a shared source clock. It divides the source by a ratio between 1 and 128, and it stops the divided clock when the tile has nothing useful to do. The tile has nothing to do when its input queue is empty, its output queue is full, or an external halt is requested. A stop does not happen at once. The block first lets the tile run nine more full output periods so that its pipeline can empty, and then holds the clock low on a period boundary. When the stall condition clears, a new output period starts on the next source cycle.

Glitch-free gating rests on an enable latch. The latch is transparent only while the source clock is low, so the enable never changes during a source high phase, and no high phase of the output is cut short or added. The ratio code is loaded only when an output period begins, so reprogramming never distorts the period in progress. The stall inputs are taken to be synchronous to the source clock and are sampled on its rising edge.

Top module: `tile_clk_throttle`

## Requirements
- R1: While reset is asserted, and after its release, the block is running with ratio code 0, so the output follows the source clock.
- R2: With ratio code c in 1..127, each output period lasts c+1 source cycles. The output is high for the first floor((c+1)/2) source cycles of the period and low for the rest.
- R3: With ratio code 0, while running, the output equals the source clock.
- R4: The ratio code is sampled only in the source cycle that begins an output period. A change in mid-period has no effect until the next period starts.
- R5: The stall condition is sampled at each period end. Suppose it is seen at one period end and at each of the next nine. The output then completes nine further full periods, and at that tenth sampled period end it stops, low.
- R6: A period end at which the stall condition is absent restarts the drain count from zero, so intermittent stalls shorter than the drain never stop the clock.
- R7: While stopped, a rising source edge that samples no stall begins a new output period in the following source cycle, using the ratio code present at that edge.
- R8: The stall condition is the OR of halt_i, in_empty_i and out_full_i, and each one alone is enough to stop the clock.
- R9: The gating enable changes only while the source clock is low. In pass-through mode, stopping and restarting never produce a partial high phase.
- R10: While stopped, the output stays low whatever the source clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code_i | input | 7 | Divide ratio minus one (0 means divide by 1, 127 means divide by 128) |
| halt_i | input | 1 | External halt request |
| in_empty_i | input | 1 | Tile input queue is empty |
| out_full_i | input | 1 | Tile output queue is full |
| clk_tile_o | output | 1 | Gated, divided tile clock |

## Verification
The bench checks both the high and the low phase of every source cycle, so it catches an off-by-one in the drain count: a design that miscounts stops one output period early or late. It toggles the ratio code in mid-period; a design that loads the code eagerly produces a stretched or shortened period. It drops the stall for one period end inside a long stall; a design that fails to clear the drain count stops the clock when it should not. It stops and restarts in pass-through mode; an enable that is not latched in the low phase shows up there as a missing or extra high phase.

// File: rtl/tile_clk_pkg.sv
`timescale 1ns/1ps
package tile_clk_pkg;

  typedef enum logic {
    GATE_STOP = 1'b0,
    GATE_RUN  = 1'b1
  } gate_e;

  localparam int DEF_MAX_RATIO = 128;
  localparam int DEF_DRAIN     = 9;

endpackage

// File: rtl/tclk_rst_sync.sv
`timescale 1ns/1ps
module tclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/tclk_div_core.sv
`timescale 1ns/1ps
module tclk_div_core #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              start_i,
  input  logic              step_i,
  output logic              period_end_o,
  output logic              hi_o,
  output logic              pass_o
);

  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              hi_q, hi_d;
  logic              pass_q, pass_d;
  logic [CODE_W:0]   half_cur, half_new, cnt_inc;

  always_comb begin
    half_cur = ({1'b0, code_q} + 1'b1) >> 1;
    half_new = ({1'b0, code_i} + 1'b1) >> 1;
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    cnt_d    = cnt_q;
    code_d   = code_q;
    hi_d     = hi_q;
    pass_d   = pass_q;
    if (start_i) begin
      cnt_d  = '0;
      code_d = code_i;
      hi_d   = (half_new != '0);
      pass_d = (code_i == '0);
    end else if (step_i) begin
      cnt_d  = cnt_q + 1'b1;
      hi_d   = (cnt_inc < half_cur);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
      hi_q   <= 1'b0;
      pass_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
      hi_q   <= hi_d;
      pass_q <= pass_d;
    end
  end

  assign period_end_o = (cnt_q == code_q);
  assign hi_o         = hi_q;
  assign pass_o       = pass_q;

  AST_END_CYCLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> !hi_q); // R2
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= code_q); // R2
  AST_CODE_HELD_MID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(code_q)); // R4

endmodule

// File: rtl/tclk_work_gate.sv
`timescale 1ns/1ps
module tclk_work_gate
  import tile_clk_pkg::*;
#(
  parameter int DRAIN = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic period_end_i,
  output logic start_o,
  output logic step_o,
  output logic run_o,
  output logic run_next_o
);

  localparam int DRN_W = $clog2(DRAIN + 1);

  gate_e             st_q, st_d;
  logic [DRN_W-1:0]  drn_q, drn_d;

  always_comb begin
    st_d    = st_q;
    drn_d   = drn_q;
    start_o = 1'b0;
    step_o  = 1'b0;
    case (st_q)
      GATE_RUN: begin
        if (!period_end_i) begin
          step_o = 1'b1;
        end else if (stall_i && (drn_q == DRN_W'(DRAIN))) begin
          st_d  = GATE_STOP;
          drn_d = '0;
        end else begin
          start_o = 1'b1;
          drn_d   = stall_i ? (drn_q + 1'b1) : '0;
        end
      end
      default: begin
        if (!stall_i) begin
          st_d    = GATE_RUN;
          start_o = 1'b1;
          drn_d   = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= GATE_RUN;
      drn_q <= '0;
    end else begin
      st_q  <= st_d;
      drn_q <= drn_d;
    end
  end

  assign run_o      = (st_q == GATE_RUN);
  assign run_next_o = (st_d == GATE_RUN);

  AST_DRAIN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_q <= DRN_W'(DRAIN)); // R5
  AST_STOP_ON_STALLED_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(period_end_i && stall_i)); // R5
  AST_NO_STOP_WITHOUT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !stall_i) |=> run_o); // R6
  AST_WAKE_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !stall_i) |=> run_o); // R7

endmodule

// File: rtl/tclk_gate_cell.sv
`timescale 1ns/1ps
module tclk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_next_i,
  input  logic hi_i,
  input  logic pass_i,
  output logic clk_o
);

  logic en_lat;

  always_latch begin
    if (!rst_ni)     en_lat <= 1'b1;
    else if (!clk_i) en_lat <= en_next_i;
  end

  assign clk_o = en_lat & (hi_i | (pass_i & clk_i));

endmodule

// File: rtl/tile_clk_throttle.sv
`timescale 1ns/1ps
module tile_clk_throttle #(
  parameter int MAX_RATIO    = tile_clk_pkg::DEF_MAX_RATIO,
  parameter int DRAIN_CYCLES = tile_clk_pkg::DEF_DRAIN
) (
  input  logic                         clk_src_i,
  input  logic                         rst_ni,
  input  logic [$clog2(MAX_RATIO)-1:0] ratio_code_i,
  input  logic                         halt_i,
  input  logic                         in_empty_i,
  output logic                         clk_tile_o,
  input  logic                         out_full_i
);

  localparam int CODE_W = $clog2(MAX_RATIO);

  logic srst_n;
  logic stall;
  logic period_end, start, step, run, run_next;
  logic div_hi, div_pass;

  assign stall = halt_i | in_empty_i | out_full_i;

  tclk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_src_i),
    .rst_ni (rst_ni),
    .rst_no (srst_n)
  );

  tclk_work_gate #(.DRAIN(DRAIN_CYCLES)) u_work_gate (
    .clk_i        (clk_src_i),
    .rst_ni       (srst_n),
    .stall_i      (stall),
    .period_end_i (period_end),
    .start_o      (start),
    .step_o       (step),
    .run_o        (run),
    .run_next_o   (run_next)
  );

  tclk_div_core #(.CODE_W(CODE_W)) u_div_core (
    .clk_i        (clk_src_i),
    .rst_ni       (srst_n),
    .code_i       (ratio_code_i),
    .start_i      (start),
    .step_i       (step),
    .period_end_o (period_end),
    .hi_o         (div_hi),
    .pass_o       (div_pass)
  );

  tclk_gate_cell u_gate_cell (
    .clk_i     (clk_src_i),
    .rst_ni    (srst_n),
    .en_next_i (run_next),
    .hi_i      (div_hi),
    .pass_i    (div_pass),
    .clk_o     (clk_tile_o)
  );

  AST_STOPPED_OUTPUT_LOW: assert property (@(negedge clk_src_i) disable iff (!srst_n)
    !run |-> !clk_tile_o); // R10

endmodule

// File: tb/tile_clk_throttle_bench.sv
`timescale 1ns/1ps
module tile_clk_throttle_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] ratio;
  logic       halt, empty, full;
  logic       clk_o;

  always #4 clk = ~clk;

  tile_clk_throttle u_tile_clk_throttle (
    .clk_src_i    (clk),
    .rst_ni       (rst_n),
    .ratio_code_i (ratio),
    .halt_i       (halt),
    .in_empty_i   (empty),
    .clk_tile_o   (clk_o),
    .out_full_i   (full)
  );

  int    tests = 0;
  int    fails = 0;
  int    edges = 0;
  bit    done  = 1'b0;
  string req_tag = "R1";

  // behavioural reference state
  int m_run = 1, m_pos = 0, m_code = 0, m_drn = 0, rst_hold = 2;

  function automatic int half_of(input int c);
    return (c + 1) / 2;
  endfunction

  function automatic bit exp_high();
    return (m_run != 0) && ((m_code == 0) || (m_pos < half_of(m_code)));
  endfunction

  function automatic bit exp_low();
    return (m_run != 0) && (m_code != 0) && (m_pos < half_of(m_code));
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %b expected %b", req_tag, what, $time, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk_o) edges++;

  always @(posedge clk) begin
    bit stall;
    stall = halt | empty | full;
    if (!rst_n) begin
      rst_hold = 2; m_run = 1; m_pos = 0; m_code = 0; m_drn = 0;
    end else if (rst_hold > 0) begin
      rst_hold--;
    end else if (m_run != 0) begin
      if (m_pos == m_code) begin
        if (stall && m_drn == 9) begin
          m_run = 0; m_drn = 0;
        end else begin
          m_pos = 0; m_code = int'(ratio);
          m_drn = stall ? m_drn + 1 : 0;
        end
      end else begin
        m_pos++;
      end
    end else if (!stall) begin
      m_run = 1; m_pos = 0; m_code = int'(ratio); m_drn = 0;
    end
  end

  // compare both phases of every source cycle
  initial begin
    forever begin
      @(posedge clk); #2;
      check(clk_o, exp_high(), "high phase");
      @(negedge clk); #2;
      check(clk_o, exp_low(), "low phase");
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edge_window(input int n, input int exp, input string tag);
    @(negedge clk);
    edges = 0;
    wait_cycles(n);
    check_int(edges, exp, tag, "rising edges in window");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(64'd1600000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ratio = 7'd0; halt = 1'b0; empty = 1'b0; full = 1'b0;
    req_tag = "R1";
    wait_cycles(6);
    rst_n = 1'b1;
    wait_cycles(4);

    req_tag = "R3";
    edge_window(20, 20, "R3");

    req_tag = "R2";
    @(negedge clk) ratio = 7'd3;
    wait_cycles(10);
    edge_window(40, 10, "R2");
    @(negedge clk) ratio = 7'd6;
    wait_cycles(10);
    edge_window(70, 10, "R2");

    req_tag = "R4";
    for (int k = 0; k < 12; k++) begin
      @(negedge clk) ratio = (k % 2 == 0) ? 7'd3 : 7'd8;
      wait_cycles(5);
    end

    req_tag = "R5";
    @(negedge clk) begin ratio = 7'd3; empty = 1'b1; end
    wait_cycles(100);
    req_tag = "R10";
    edge_window(50, 0, "R10");

    req_tag = "R7";
    @(negedge clk) empty = 1'b0;
    @(posedge clk); #1;
    tests++;
    if (clk_o !== 1'b1) begin
      fails++;
      $display("FAIL R7 restart pulse: got %b expected 1", clk_o);
    end
    wait_cycles(20);

    req_tag = "R6";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) empty = 1'b1;
      wait_cycles(30);
      @(negedge clk) empty = 1'b0;
      wait_cycles(4);
    end
    edge_window(40, 10, "R6");

    req_tag = "R8";
    @(negedge clk) begin ratio = 7'd1; full = 1'b1; end
    wait_cycles(60);
    edge_window(20, 0, "R8");
    @(negedge clk) full = 1'b0;
    wait_cycles(10);
    @(negedge clk) halt = 1'b1;
    wait_cycles(60);
    edge_window(20, 0, "R8");
    @(negedge clk) halt = 1'b0;
    wait_cycles(10);

    req_tag = "R9";
    @(negedge clk) ratio = 7'd0;
    wait_cycles(5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) halt = 1'b1;
      wait_cycles(15 + k);
      @(negedge clk) halt = 1'b0;
      wait_cycles(3 + k);
    end
    wait_cycles(10);

    req_tag = "R2";
    @(negedge clk) ratio = 7'd127;
    wait_cycles(140);
    edge_window(256, 2, "R2");
    @(negedge clk) empty = 1'b1;
    wait_cycles(1400);
    req_tag = "R10";
    edge_window(64, 0, "R10");
    req_tag = "R7";
    @(negedge clk) begin empty = 1'b0; ratio = 7'd4; end
    wait_cycles(30);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule